// File: doc/BRIEF.md
# Precision Time Event Stamper

This block watches one byte-wide GMII stream, from either the transmit or the receive side. When a frame's start delimiter arrives it captures the current time of day. It then walks the frame headers byte by byte to find a precision-time-protocol message. The message may sit right after the Ethernet header, inside UDP over IPv4 or IPv6, or behind a stack of MPLS labels.

When a message is found, its type is enabled in a software mask, and the frame is clean and long enough, the block builds one 128-bit record. The record holds the captured time, the message type, a checksum field and the sequence identifier. Records go into a small in-order queue. A host drains the queue through a valid/ready output.

Back-pressure works as follows:
- While `rec_valid` is high and `rec_ready` is low, the head record stays on `rec_data` unchanged.
- A record leaves the queue only on a cycle where both signals are high.
- The input side cannot be stalled. A record that finds the queue full is discarded, and a sticky overflow flag is raised.

Top module: `ptp_evt_stamper`

## Requirements
- R1: A frame is accepted only when its lead-in is exactly seven 0x55 bytes followed by 0xD5. A lead-in with fewer or more 0x55 bytes yields no record.
- R2: The seconds and nanoseconds in a record are the `tod_sec`/`tod_ns` values present in the cycle the accepted 0xD5 byte is on `gm_data`.
- R3: Header offsets count from the first byte after 0xD5. The EtherType is at bytes 12–13, and 0x88F7 means the message starts at byte 14.
- R4: EtherType 0x0800 leads to an IPv4 header (version nibble 4, IHL ≥ 5, IHL honoured). Its protocol byte 9 must be 17. The UDP destination port (bytes 2–3 of UDP) must be 319 or 320; any other port yields no record.
- R5: EtherType 0x86DD leads to an IPv6 header (version nibble 6) of 40 bytes whose next-header byte 6 must be 17. UDP then follows as in R4.
- R6: EtherType 0x8847 starts a stack of 4-byte MPLS labels. Labels are skipped until one has bit 0 of its third byte set. The next byte's version nibble then selects IPv4 or IPv6.
- R7: The message type is the low nibble of message byte 0. A record is produced only if `type_mask[type]` is 1.
- R8: Record layout, most to least significant:
  - bits [127:112]: zero;
  - bits [111:64]: seconds;
  - bits [63:32]: nanoseconds;
  - bits [31:28]: type;
  - bits [27:16]: checksum field, which is the low 12 bits of the UDP checksum, or 0 when the message follows the Ethernet header directly;
  - bits [15:0]: sequence identifier, taken from message bytes 30–31 with byte 30 as the high byte.
- R9: A frame with `gm_err` high on any byte from the delimiter to the last sequence byte yields no record. So does a frame whose `gm_en` drops before the last sequence byte.
- R10: While `rec_valid` is high and `rec_ready` is low, `rec_valid` stays high and `rec_data` stays stable. Records leave in arrival order.
- R11: The queue holds `DEPTH` records. A record arriving while the queue is full is dropped and `ovf_flag` becomes 1 and stays 1.
- R12: After reset `rec_valid` and `ovf_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | GMII byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gm_data | input | 8 | GMII data byte |
| gm_en | input | 1 | GMII data enable |
| gm_err | input | 1 | GMII error |
| tod_sec | input | 48 | Current time, seconds |
| tod_ns | input | 32 | Current time, nanoseconds |
| type_mask | input | 16 | One enable bit per message type |
| rec_valid | output | 1 | Queue head holds a record |
| rec_ready | input | 1 | Host accepts the head record |
| rec_data | output | 128 | Head record |
| ovf_flag | output | 1 | Sticky: a record was dropped on a full queue |

## Verification
The assertions assume the host may stall `rec_ready` for any number of cycles. They also assume `gm_en` drops between frames, because that is the only point where delimiter hunting restarts. The stimulus always leaves several idle cycles between frames and changes `type_mask` only while the line is idle. Each frame is built from fixed header templates, so every header field the parser tests has a value the bench chose on purpose.

// File: rtl/ptp_stamp_pkg.sv
package ptp_stamp_pkg;
  localparam logic [7:0]  LEAD_BYTE  = 8'h55;
  localparam logic [7:0]  DELIM_BYTE = 8'hD5;
  localparam logic [15:0] ET_DIRECT  = 16'h88F7;
  localparam logic [15:0] ET_LABEL   = 16'h8847;
  localparam logic [15:0] ET_V4      = 16'h0800;
  localparam logic [15:0] ET_V6      = 16'h86DD;
  localparam logic [15:0] PORT_EVT   = 16'd319;
  localparam logic [15:0] PORT_GEN   = 16'd320;
  localparam logic [7:0]  PROTO_UDP  = 8'd17;
  localparam int unsigned REC_W      = 128;

  typedef enum logic [3:0] {
    PS_IDLE, PS_MAC, PS_LABEL, PS_IPSEL, PS_V4, PS_V6, PS_UDP, PS_MSG, PS_SKIP
  } parse_st_t;

  function automatic logic [REC_W-1:0] pack_rec(
    input logic [47:0] sec, input logic [31:0] ns, input logic [3:0] typ,
    input logic [11:0] ck, input logic [15:0] seq);
    return {16'h0000, sec, ns, typ, ck, seq};
  endfunction
endpackage

// File: rtl/ptp_lead_in.sv
module ptp_lead_in
  import ptp_stamp_pkg::*;
#(
  parameter int unsigned LEAD_LEN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] d,
  input  logic       en,
  output logic       sof,
  output logic       body_vld
);
  localparam int unsigned CW = $clog2(LEAD_LEN + 2);
  localparam logic [CW-1:0] LEAD_MAX = CW'(LEAD_LEN + 1);

  logic [CW-1:0] lead_cnt;
  logic          hunting;
  logic          in_body;

  assign sof      = en && hunting && !in_body && (d == DELIM_BYTE) && (lead_cnt == CW'(LEAD_LEN));
  assign body_vld = en && in_body;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      lead_cnt <= '0;
      hunting  <= 1'b1;
      in_body  <= 1'b0;
    end else if (hunting && !in_body) begin
      if (d == LEAD_BYTE) begin
        if (lead_cnt != LEAD_MAX) lead_cnt <= lead_cnt + 1'b1;
      end else if (sof) begin
        in_body <= 1'b1;
        hunting <= 1'b0;
      end else begin
        hunting <= 1'b0;
      end
    end
  end

  // R1: the body only opens right after a delimiter byte on the line
  p_body_after_delim_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_body) |-> ($past(d) == DELIM_BYTE) && $past(en));
endmodule

// File: rtl/ptp_pkt_parse.sv
module ptp_pkt_parse
  import ptp_stamp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       d,
  input  logic             en,
  input  logic             err,
  input  logic             sof,
  input  logic             body_vld,
  input  logic [47:0]      tod_sec,
  input  logic [31:0]      tod_ns,
  input  logic [15:0]      mask,
  output logic             rec_push,
  output logic [REC_W-1:0] rec_data
);
  parse_st_t   st;
  logic [5:0]  cnt;
  logic [7:0]  hi_b;
  logic [3:0]  ihl;
  logic        bos;
  logic [11:0] ck;
  logic [3:0]  typ;
  logic        err_seen;
  logic [47:0] ts_sec;
  logic [31:0] ts_ns;
  logic [15:0] pair;

  assign pair = {hi_b, d};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PS_IDLE;
      cnt      <= '0;
      hi_b     <= '0;
      ihl      <= '0;
      bos      <= 1'b0;
      ck       <= '0;
      typ      <= '0;
      err_seen <= 1'b0;
      ts_sec   <= '0;
      ts_ns    <= '0;
      rec_push <= 1'b0;
      rec_data <= '0;
    end else begin
      rec_push <= 1'b0;
      if (sof) begin
        ts_sec   <= tod_sec;
        ts_ns    <= tod_ns;
        st       <= PS_MAC;
        cnt      <= '0;
        ck       <= '0;
        err_seen <= err;
      end else if (!en) begin
        st <= PS_IDLE;
      end else if (body_vld) begin
        err_seen <= err_seen | err;
        cnt      <= cnt + 1'b1;
        unique case (st)
          PS_MAC: begin
            if (cnt == 6'd12) hi_b <= d;
            if (cnt == 6'd13) begin
              cnt <= '0;
              if (pair == ET_DIRECT)                      st <= PS_MSG;
              else if (pair == ET_LABEL)                  st <= PS_LABEL;
              else if (pair == ET_V4 || pair == ET_V6)    st <= PS_IPSEL;
              else                                        st <= PS_SKIP;
            end
          end
          PS_LABEL: begin
            if (cnt == 6'd2) bos <= d[0];
            if (cnt == 6'd3) begin
              cnt <= '0;
              if (bos) st <= PS_IPSEL;
            end
          end
          PS_IPSEL: begin
            cnt <= 6'd1;
            if (d[7:4] == 4'd4 && d[3:0] >= 4'd5) begin
              ihl <= d[3:0];
              st  <= PS_V4;
            end else if (d[7:4] == 4'd6) begin
              st <= PS_V6;
            end else begin
              st <= PS_SKIP;
            end
          end
          PS_V4: begin
            if (cnt == 6'd9 && d != PROTO_UDP) st <= PS_SKIP;
            else if (cnt == 6'({ihl, 2'b00} - 6'd1)) begin
              cnt <= '0;
              st  <= PS_UDP;
            end
          end
          PS_V6: begin
            if (cnt == 6'd6 && d != PROTO_UDP) st <= PS_SKIP;
            else if (cnt == 6'd39) begin
              cnt <= '0;
              st  <= PS_UDP;
            end
          end
          PS_UDP: begin
            if (cnt == 6'd2 || cnt == 6'd6) hi_b <= d;
            if (cnt == 6'd3 && pair != PORT_EVT && pair != PORT_GEN) st <= PS_SKIP;
            if (cnt == 6'd7) begin
              ck  <= pair[11:0];
              cnt <= '0;
              st  <= PS_MSG;
            end
          end
          PS_MSG: begin
            if (cnt == 6'd0)  typ  <= d[3:0];
            if (cnt == 6'd30) hi_b <= d;
            if (cnt == 6'd31) begin
              st <= PS_SKIP;
              if (mask[typ] && !err_seen && !err) begin
                rec_push <= 1'b1;
                rec_data <= pack_rec(ts_sec, ts_ns, typ, ck, pair);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R7: a record only appears for a type enabled in the mask one cycle earlier
  p_push_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_push |-> (($past(mask) & (16'h1 << rec_data[31:28])) != 16'h0));
  // R9: the last sequence byte carried no line error
  p_push_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_push |-> !$past(err) && $past(en));
  // R2: the captured time holds steady for the whole frame body
  p_ts_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (body_vld && !sof) |=> $stable(ts_ns) && $stable(ts_sec));
endmodule

// File: rtl/ptp_rec_queue.sv
module ptp_rec_queue #(
  parameter int unsigned W     = 128,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         ovf
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] fill;
  logic          full, do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fill == CW'(DEPTH));
  assign do_push   = push && !full;
  assign out_valid = (fill != '0);
  assign do_pop    = out_valid && out_ready;
  assign out_data  = mem[rp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
      ovf  <= 1'b0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      fill <= fill + CW'(do_push) - CW'(do_pop);
      if (push && full) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  // R10: a stalled head record neither vanishes nor changes
  p_hold_head_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data));
  // R11: a push into a full queue leaves the overflow flag set
  p_drop_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> ovf);
  // R11: overflow is sticky
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  // R11: occupancy never exceeds the depth
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
endmodule

// File: rtl/ptp_evt_stamper.sv
module ptp_evt_stamper
  import ptp_stamp_pkg::*;
#(
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned LEAD_LEN = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [7:0]   gm_data,
  input  logic         gm_en,
  input  logic         gm_err,
  input  logic [47:0]  tod_sec,
  input  logic [31:0]  tod_ns,
  input  logic [15:0]  type_mask,
  output logic         rec_valid,
  input  logic         rec_ready,
  output logic [127:0] rec_data,
  output logic         ovf_flag
);
  logic             sof, body_vld, push;
  logic [REC_W-1:0] push_rec;

  ptp_lead_in #(.LEAD_LEN(LEAD_LEN)) u_lead (
    .clk(clk), .rst_n(rst_n), .d(gm_data), .en(gm_en),
    .sof(sof), .body_vld(body_vld)
  );

  ptp_pkt_parse u_parse (
    .clk(clk), .rst_n(rst_n), .d(gm_data), .en(gm_en), .err(gm_err),
    .sof(sof), .body_vld(body_vld), .tod_sec(tod_sec), .tod_ns(tod_ns),
    .mask(type_mask), .rec_push(push), .rec_data(push_rec)
  );

  ptp_rec_queue #(.W(REC_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_rec),
    .out_valid(rec_valid), .out_ready(rec_ready), .out_data(rec_data),
    .ovf(ovf_flag)
  );

  // R12: nothing is offered in the cycle after reset
  p_reset_empty_r12: assert property (@(posedge clk)
    $past(!rst_n) |-> !rec_valid && !ovf_flag);
endmodule

// File: tb/ptp_evt_stamper_bench.sv
module ptp_evt_stamper_bench;
  localparam int DEPTH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [7:0]   gm_data = 8'h00;
  logic         gm_en = 1'b0;
  logic         gm_err = 1'b0;
  logic [47:0]  tod_sec = 48'h0000_1234_5678;
  logic [31:0]  tod_ns = 32'd1000;
  logic [15:0]  type_mask = 16'hFFFF;
  logic         rec_valid;
  logic         rec_ready = 1'b0;
  logic [127:0] rec_data;
  logic         ovf_flag;

  int checks = 0;
  int bad = 0;
  logic [7:0]   fb[$];
  logic [127:0] exp_q[$];
  logic [31:0]  ts_ns_x;
  logic [47:0]  ts_sec_x;

  always #4 clk = ~clk;

  ptp_evt_stamper #(.DEPTH(DEPTH)) u_ptp_evt_stamper (
    .clk(clk), .rst_n(rst_n), .gm_data(gm_data), .gm_en(gm_en), .gm_err(gm_err),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .type_mask(type_mask),
    .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
    .ovf_flag(ovf_flag)
  );

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic en, input logic er);
    @(negedge clk);
    gm_data = b; gm_en = en; gm_err = er;
    tod_ns = tod_ns + 32'd8;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(8'h00, 1'b0, 1'b0);
  endtask

  // frame builders
  task automatic fb_eth(input logic [15:0] et);
    fb.delete();
    fb.push_back(8'h01); fb.push_back(8'h1B); fb.push_back(8'h19);
    fb.push_back(8'h00); fb.push_back(8'h00); fb.push_back(8'h00);
    for (int i = 0; i < 6; i++) fb.push_back(8'h10 + 8'(i));
    fb.push_back(et[15:8]); fb.push_back(et[7:0]);
  endtask

  task automatic fb_label(input bit last);
    fb.push_back(8'h00); fb.push_back(8'h12); fb.push_back({7'h03, last}); fb.push_back(8'h40);
  endtask

  task automatic fb_v4(input logic [3:0] ihl);
    fb.push_back({4'h4, ihl});
    for (int i = 1; i < 9; i++) fb.push_back(8'h00);
    fb.push_back(8'd17);
    for (int i = 10; i < 4 * int'(ihl); i++) fb.push_back(8'hC0 + 8'(i));
  endtask

  task automatic fb_v6();
    fb.push_back(8'h60);
    for (int i = 1; i < 6; i++) fb.push_back(8'h00);
    fb.push_back(8'd17); fb.push_back(8'd64);
    for (int i = 8; i < 40; i++) fb.push_back(8'hA0 + 8'(i));
  endtask

  task automatic fb_udp(input logic [15:0] port, input logic [15:0] ck);
    fb.push_back(8'h01); fb.push_back(8'h3F);
    fb.push_back(port[15:8]); fb.push_back(port[7:0]);
    fb.push_back(8'h00); fb.push_back(8'h40);
    fb.push_back(ck[15:8]); fb.push_back(ck[7:0]);
  endtask

  task automatic fb_msg(input logic [3:0] typ, input logic [15:0] seq);
    fb.push_back({4'h0, typ}); fb.push_back(8'h02);
    for (int i = 2; i < 30; i++) fb.push_back(8'(i * 3));
    fb.push_back(seq[15:8]); fb.push_back(seq[7:0]);
    for (int i = 0; i < 10; i++) fb.push_back(8'hEE);
  endtask

  // send lead-in + fb; err_at < 0: none; keep <= 0: whole frame
  task automatic send(input int lead, input int err_at, input int keep);
    int n;
    n = (keep > 0) ? keep : fb.size();
    for (int i = 0; i < lead; i++) drive(8'h55, 1'b1, 1'b0);
    drive(8'hD5, 1'b1, 1'b0);
    ts_ns_x = tod_ns; ts_sec_x = tod_sec;
    for (int i = 0; i < n; i++) drive(fb[i], 1'b1, (i == err_at));
    idle(6);
  endtask

  function automatic logic [127:0] mk(input logic [3:0] t, input logic [11:0] ck, input logic [15:0] seq);
    return {16'h0, ts_sec_x, ts_ns_x, t, ck, seq};
  endfunction

  task automatic pop_check(input logic [127:0] exp, input string tag);
    int w = 0;
    while (!rec_valid && w < 60) begin @(negedge clk); w++; end
    check(rec_valid == 1'b1, {tag, " valid"}, 128'(rec_valid), 128'd1);
    check(rec_data == exp, {tag, " record"}, rec_data, exp);
    rec_ready = 1'b1;
    @(negedge clk);
    rec_ready = 1'b0;
  endtask

  task automatic expect_none(input string tag);
    repeat (20) @(negedge clk);
    check(rec_valid == 1'b0, tag, 128'(rec_valid), 128'd0);
  endtask

  task automatic t_reset();
    check(rec_valid == 1'b0, "R12 valid after reset", 128'(rec_valid), 128'd0);
    check(ovf_flag == 1'b0, "R12 ovf after reset", 128'(ovf_flag), 128'd0);
  endtask

  task automatic t_direct();
    fb_eth(16'h88F7); fb_msg(4'd0, 16'h1234); send(7, -1, 0);
    pop_check(mk(4'd0, 12'h000, 16'h1234), "R3 R2 R8 direct");
  endtask

  task automatic t_v4();
    fb_eth(16'h0800); fb_v4(4'd6); fb_udp(16'd319, 16'hABCD); fb_msg(4'd1, 16'h0F0E); send(7, -1, 0);
    pop_check(mk(4'd1, 12'hBCD, 16'h0F0E), "R4 R8 ipv4 options");
  endtask

  task automatic t_v6();
    fb_eth(16'h86DD); fb_v6(); fb_udp(16'd320, 16'h1F00); fb_msg(4'd8, 16'hBEEF); send(7, -1, 0);
    pop_check(mk(4'd8, 12'hF00, 16'hBEEF), "R5 ipv6");
  endtask

  task automatic t_label();
    fb_eth(16'h8847); fb_label(1'b0); fb_label(1'b1);
    fb_v4(4'd5); fb_udp(16'd319, 16'h0123); fb_msg(4'd3, 16'h0042); send(7, -1, 0);
    pop_check(mk(4'd3, 12'h123, 16'h0042), "R6 mpls stack");
    fb_eth(16'h8847); fb_label(1'b1);
    fb_v6(); fb_udp(16'd320, 16'h0555); fb_msg(4'd2, 16'h7777); send(7, -1, 0);
    pop_check(mk(4'd2, 12'h555, 16'h7777), "R6 mpls ipv6");
  endtask

  task automatic t_mask();
    type_mask = 16'hFFFE;
    fb_eth(16'h88F7); fb_msg(4'd0, 16'h0001); send(7, -1, 0);
    expect_none("R7 masked type");
    fb_eth(16'h88F7); fb_msg(4'd2, 16'h0002); send(7, -1, 0);
    pop_check(mk(4'd2, 12'h000, 16'h0002), "R7 enabled type");
    type_mask = 16'hFFFF;
  endtask

  task automatic t_lead();
    fb_eth(16'h88F7); fb_msg(4'd0, 16'h0003); send(3, -1, 0);
    expect_none("R1 short lead-in");
    fb_eth(16'h88F7); fb_msg(4'd0, 16'h0004); send(8, -1, 0);
    expect_none("R1 long lead-in");
  endtask

  task automatic t_bad_frames();
    fb_eth(16'h88F7); fb_msg(4'd0, 16'h0005); send(7, 20, 0);
    expect_none("R9 line error");
    fb_eth(16'h88F7); fb_msg(4'd0, 16'h0006); send(7, -1, 14 + 31);
    expect_none("R9 truncated");
    fb_eth(16'h0800); fb_v4(4'd5); fb_udp(16'd321, 16'h0000); fb_msg(4'd0, 16'h0007); send(7, -1, 0);
    expect_none("R4 other port");
  endtask

  task automatic t_stall();
    logic [127:0] a, b;
    fb_eth(16'h88F7); fb_msg(4'd1, 16'h0A0A); send(7, -1, 0); a = mk(4'd1, 12'h0, 16'h0A0A);
    fb_eth(16'h88F7); fb_msg(4'd3, 16'h0B0B); send(7, -1, 0); b = mk(4'd3, 12'h0, 16'h0B0B);
    repeat (15) @(negedge clk);
    check(rec_valid == 1'b1 && rec_data == a, "R10 head held under stall", rec_data, a);
    pop_check(a, "R10 first out");
    pop_check(b, "R10 second out");
    expect_none("R10 drained");
  endtask

  task automatic t_overflow();
    for (int k = 0; k <= DEPTH; k++) begin
      fb_eth(16'h88F7); fb_msg(4'd0, 16'(16'h100 + k)); send(7, -1, 0);
      exp_q.push_back(mk(4'd0, 12'h0, 16'(16'h100 + k)));
    end
    @(negedge clk);
    check(ovf_flag == 1'b1, "R11 overflow flag", 128'(ovf_flag), 128'd1);
    for (int k = 0; k < DEPTH; k++) pop_check(exp_q[k], "R11 kept record");
    expect_none("R11 extra dropped");
    check(ovf_flag == 1'b1, "R11 flag sticky", 128'(ovf_flag), 128'd1);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_direct();
    t_v4();
    t_v6();
    t_label();
    t_mask();
    t_lead();
    t_bad_frames();
    t_stall();
    t_overflow();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule